// File: doc/BRIEF.md
# Segmented I2C Memory Target

This block is an I2C target that serves a byte-wide memory array of several 256-byte segments. It takes SCL and SDA that have already been synchronized and cleaned up, and it returns one open-drain enable for SDA. When the enable is high, the line is pulled low. Memory is reached through the device address pair A0h (write) and A1h (read). A separate write-only device address, 60h, holds a segment pointer. The pointer chooses which 256-byte segment the next memory access uses.

A host that never touches the pointer sees a plain EEPROM with 8-bit offsets, because the pointer drops back to segment 0 at every STOP. Written bytes are gathered in a page buffer. They are committed to the array only after STOP. The commit runs inside a programming window whose length is a parameter in clock cycles. During that window the target does not answer its address.

Top module: `i2c_seg_eeprom`

## Requirements
- R1: After a START, the address byte 1010_0000 (A0h, write) and the address byte 1010_0001 (A1h, read) are acknowledged when the target is not programming. Any other address except 60h (for example A4h) is not acknowledged, and SDA stays released for the rest of that transaction.
- R2: A write to address 60h is acknowledged. So is the byte that follows it. The low SEG_BITS bits of that byte become the segment pointer, and the upper bits are ignored. The memory location used by A0h/A1h accesses is {segment, offset}.
- R3: The segment pointer is 0 after reset and after every STOP. A repeated START does not change it.
- R4: The address byte 61h (an attempt to read the pointer) is not acknowledged.
- R5: A random read works as follows: A0h, then the offset byte, then a repeated START, then A1h. It returns the byte at the loaded offset. The repeated START does not disturb the offset.
- R6: After each byte sent in a read, the offset advances by one. It wraps from FFh to 00h inside the same segment.
- R7: In a write, every data byte after the offset byte is acknowledged. Each byte lands at the current offset. The low 4 offset bits then advance and roll over inside the 16-byte page, while the upper offset bits stay fixed. A 17th byte therefore replaces the first byte of the page.
- R8: Written bytes reach the array only after STOP. A write transaction that stops right after the offset byte leaves memory unchanged and does not start a programming window.
- R9: For PROG_CYCLES clock cycles after the STOP of a write that carried data, every address, including A0h, is not acknowledged and SDA is never pulled low. Afterwards A0h is acknowledged again.
- R10: After reset, SDA is released (sda_oe_o = 0).
- R11: When the host answers a read byte with NACK, the target releases SDA and sends no further data before the STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; oversamples the I2C bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized, filtered SCL level |
| sda_i | input | 1 | Synchronized, filtered SDA level (wired bus value) |
| sda_oe_o | output | 1 | Open-drain SDA enable; 1 pulls SDA low |

## Verification
Assertions check these properties on every cycle:
- SDA is released in every receiving state and right after a START.
- The segment pointer is back at 0 in the cycle after a STOP.
- SDA is never pulled low while the programming window is open.
- The page buffer takes no byte while the window is open, and the window opens only on a STOP.

The behaviours that depend on data can only be shown by the bench scenarios that run whole transactions and read back what was stored: the segment routing, the offset wrap at FFh, the page roll-over with the 17th byte, the empty write that commits nothing, and the acknowledge pattern for each address.

// File: rtl/i2c_seg_pkg.sv
package i2c_seg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_OFFS,
    ST_OFFS_ACK,
    ST_SEGB,
    ST_SEG_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RD_ACK,
    ST_WAIT
  } seg_state_e;

  // 7-bit device addresses
  localparam logic [6:0] MEM_DEV = 7'h50;  // A0h / A1h
  localparam logic [6:0] PTR_DEV = 7'h30;  // 60h (write only)

endpackage

// File: rtl/seg_bus_cond.sv
module seg_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/seg_mem_array.sv
module seg_mem_array #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cell_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) cell_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = cell_q[raddr_i];

endmodule

// File: rtl/seg_page_commit.sv
module seg_page_commit #(
  parameter int ADDR_W      = 10,
  parameter int PAGE_BYTES  = 16,
  parameter int PROG_CYCLES = 5000
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 pw_en_i,
  input  logic [$clog2(PAGE_BYTES)-1:0]        pw_idx_i,
  input  logic [7:0]                           pw_data_i,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] pw_row_i,
  input  logic                                 commit_req_i,
  output logic                                 busy_o,
  output logic                                 mem_we_o,
  output logic [ADDR_W-1:0]                    mem_waddr_o,
  output logic [7:0]                           mem_wdata_o
);

  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int ROW_W  = ADDR_W - PAGE_W;
  localparam int CNT_W  = $clog2(PROG_CYCLES);

  logic [7:0]            buf_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q, mask_d;
  logic [ROW_W-1:0]      row_q, row_d;
  logic                  busy_q, busy_d;
  logic [CNT_W-1:0]      tmr_q, tmr_d;
  logic [PAGE_W:0]       idx_q, idx_d;
  logic                  fill_en;

  assign fill_en = pw_en_i & ~busy_q;

  always_comb begin
    mask_d = mask_q;
    row_d  = row_q;
    busy_d = busy_q;
    tmr_d  = tmr_q;
    idx_d  = idx_q;
    if (!busy_q) begin
      if (fill_en) begin
        mask_d[pw_idx_i] = 1'b1;
        row_d            = pw_row_i;
      end
      if (commit_req_i && (mask_q != '0)) begin
        busy_d = 1'b1;
        tmr_d  = CNT_W'(PROG_CYCLES - 1);
        idx_d  = '0;
      end
    end else begin
      if (!idx_q[PAGE_W]) idx_d = idx_q + (PAGE_W+1)'(1);
      if (tmr_q == '0) begin
        busy_d = 1'b0;
        mask_d = '0;
      end else begin
        tmr_d = tmr_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      row_q  <= '0;
      busy_q <= 1'b0;
      tmr_q  <= '0;
      idx_q  <= '0;
    end else begin
      mask_q <= mask_d;
      row_q  <= row_d;
      busy_q <= busy_d;
      tmr_q  <= tmr_d;
      idx_q  <= idx_d;
    end
  end

  // page data storage, no reset needed
  always_ff @(posedge clk) begin
    if (fill_en) buf_q[pw_idx_i] <= pw_data_i;
  end

  assign busy_o      = busy_q;
  assign mem_we_o    = busy_q & ~idx_q[PAGE_W] & mask_q[idx_q[PAGE_W-1:0]];
  assign mem_waddr_o = {row_q, idx_q[PAGE_W-1:0]};
  assign mem_wdata_o = buf_q[idx_q[PAGE_W-1:0]];

  AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(commit_req_i)); // R8
  AST_NO_FILL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !pw_en_i); // R9

endmodule

// File: rtl/i2c_seg_eeprom.sv
module i2c_seg_eeprom #(
  parameter int SEG_BITS    = 2,
  parameter int PAGE_BYTES  = 16,
  parameter int PROG_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  import i2c_seg_pkg::*;

  localparam int ADDR_W = SEG_BITS + 8;
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int ROW_W  = ADDR_W - PAGE_W;

  logic scl_rise, scl_fall, start_w, stop_w, busy_w;
  logic mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [7:0] mem_wdata, mem_rdata;

  seg_state_e state_q, state_d;
  logic [7:0] sh_q, sh_d, off_q, off_d;
  logic [3:0] bit_q, bit_d;
  logic [SEG_BITS-1:0] seg_q, seg_d;
  logic rw_q, rw_d, mack_q, mack_d, oe_q, oe_d;
  logic pw_en;
  logic byte_done;

  seg_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_w), .stop_o(stop_w)
  );

  seg_page_commit #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)) u_commit (
    .clk(clk), .rst_n(rst_n),
    .pw_en_i(pw_en), .pw_idx_i(off_q[PAGE_W-1:0]), .pw_data_i(sh_q),
    .pw_row_i(ROW_W'({seg_q, off_q[7:PAGE_W]})),
    .commit_req_i(stop_w), .busy_o(busy_w),
    .mem_we_o(mem_we), .mem_waddr_o(mem_waddr), .mem_wdata_o(mem_wdata)
  );

  seg_mem_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we_i(mem_we), .waddr_i(mem_waddr), .wdata_i(mem_wdata),
    .raddr_i({seg_q, off_q}), .rdata_o(mem_rdata)
  );

  assign byte_done = scl_fall & (bit_q == 4'd8);

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    bit_d   = bit_q;
    off_d   = off_q;
    seg_d   = seg_q;
    rw_d    = rw_q;
    mack_d  = mack_q;
    oe_d    = oe_q;
    pw_en   = 1'b0;
    if (stop_w) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
      seg_d   = '0;
    end else if (start_w) begin
      state_d = ST_ADDR;
      oe_d    = 1'b0;
      bit_d   = '0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_OFFS, ST_SEGB, ST_WDATA: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_i};
            bit_d = bit_q + 4'd1;
          end
          if (byte_done) begin
            bit_d = '0;
            oe_d  = 1'b1;
            unique case (state_q)
              ST_ADDR: begin
                rw_d = sh_q[0];
                if (!busy_w && (sh_q[7:1] == MEM_DEV || sh_q == {PTR_DEV, 1'b0}))
                  state_d = ST_ADDR_ACK;
                else begin
                  state_d = ST_WAIT;
                  oe_d    = 1'b0;
                end
              end
              ST_OFFS: begin
                off_d   = sh_q;
                state_d = ST_OFFS_ACK;
              end
              ST_SEGB: begin
                seg_d   = sh_q[SEG_BITS-1:0];
                state_d = ST_SEG_ACK;
              end
              default: begin
                pw_en   = 1'b1;
                off_d   = {off_q[7:PAGE_W], off_q[PAGE_W-1:0] + 1'b1};
                state_d = ST_WDATA_ACK;
              end
            endcase
          end
        end
        ST_ADDR_ACK: if (scl_fall) begin
          oe_d = 1'b0;
          if (sh_q[7:1] == PTR_DEV) state_d = ST_SEGB;
          else if (rw_q) begin
            state_d = ST_RDATA;
            sh_d    = mem_rdata;
            off_d   = off_q + 8'd1;
            oe_d    = ~mem_rdata[7];
            bit_d   = '0;
          end else state_d = ST_OFFS;
        end
        ST_OFFS_ACK, ST_WDATA_ACK: if (scl_fall) begin
          oe_d    = 1'b0;
          state_d = ST_WDATA;
        end
        ST_SEG_ACK: if (scl_fall) begin
          oe_d    = 1'b0;
          state_d = ST_WAIT;
        end
        ST_RDATA: if (scl_fall) begin
          if (bit_q == 4'd7) begin
            oe_d    = 1'b0;
            bit_d   = '0;
            state_d = ST_RD_ACK;
          end else begin
            bit_d = bit_q + 4'd1;
            sh_d  = {sh_q[6:0], 1'b0};
            oe_d  = ~sh_q[6];
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) mack_d = ~sda_i;
          if (scl_fall) begin
            if (mack_q) begin
              state_d = ST_RDATA;
              sh_d    = mem_rdata;
              off_d   = off_q + 8'd1;
              oe_d    = ~mem_rdata[7];
            end else state_d = ST_WAIT;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      bit_q   <= '0;
      off_q   <= '0;
      seg_q   <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      bit_q   <= bit_d;
      off_q   <= off_d;
      seg_q   <= seg_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
      oe_q    <= oe_d;
    end
  end

  assign sda_oe_o = oe_q;

  AST_RX_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q inside {ST_IDLE, ST_ADDR, ST_OFFS, ST_SEGB, ST_WDATA, ST_WAIT}) |-> !oe_q); // R1
  AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_w) |-> (state_q == ST_ADDR && !oe_q)); // R1
  AST_SEG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_w) |-> (seg_q == '0)); // R3
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w |-> !oe_q); // R9

endmodule

// File: tb/i2c_seg_eeprom_bench.sv
module i2c_seg_eeprom_bench;

  localparam int PROG = 200;

  logic clk, rst_n, scl_m, sda_m, sda_oe_o, sda_line;
  int n_chk, n_bad;
  bit finished;
  logic [7:0] got [32];

  assign sda_line = sda_m & ~sda_oe_o;

  i2c_seg_eeprom #(.SEG_BITS(2), .PAGE_BYTES(16), .PROG_CYCLES(PROG)) u_i2c_seg_eeprom (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic q();
    repeat (4) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q(); scl_m = 1'b1; q(); scl_m = 1'b0;
    end
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); ack = ~sda_line; scl_m = 1'b0;
  endtask

  task automatic rbyte(input bit mack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); scl_m = 1'b1; q(); d[i] = sda_line; scl_m = 1'b0;
    end
    sda_m = ~mack; q(); scl_m = 1'b1; q(); scl_m = 1'b0; q(); sda_m = 1'b1;
  endtask

  // write n bytes first, first+1, ... ; optional segment pointer
  task automatic wr_seq(input bit use_seg, input logic [7:0] segv, input logic [7:0] off,
                        input int n, input logic [7:0] first, input bit settle);
    bit ack;
    i2c_start();
    if (use_seg) begin
      wbyte(8'h60, ack); chk("R2 ptr addr ack", ack, 1);
      wbyte(segv, ack);  chk("R2 ptr data ack", ack, 1);
      i2c_start();
    end
    wbyte(8'hA0, ack); chk("R1 A0 ack", ack, 1);
    wbyte(off, ack);   chk("R1 offset ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      wbyte(first + 8'(i), ack); chk("R7 data ack", ack, 1);
    end
    i2c_stop();
    if (settle) repeat (PROG + 50) @(negedge clk);
  endtask

  task automatic rd_seq(input bit use_seg, input logic [7:0] segv, input logic [7:0] off, input int n);
    bit ack;
    i2c_start();
    if (use_seg) begin
      wbyte(8'h60, ack); wbyte(segv, ack); i2c_start();
    end
    wbyte(8'hA0, ack); wbyte(off, ack);
    i2c_start();
    wbyte(8'hA1, ack); chk("R1 A1 ack", ack, 1);
    for (int i = 0; i < n; i++) rbyte(i != n - 1, got[i]);
    q(); chk("R11 released after NACK", sda_oe_o, 0);
    i2c_stop();
  endtask

  task automatic t_reset();
    chk("R10 sda released after reset", sda_oe_o, 0);
  endtask

  task automatic t_byte_busy();
    bit ack;
    wr_seq(1'b0, 8'h00, 8'h10, 1, 8'h5A, 1'b0);
    i2c_start(); wbyte(8'hA0, ack);
    chk("R9 no ack while programming", ack, 0);
    chk("R9 sda released while programming", sda_oe_o, 0);
    i2c_stop();
    repeat (PROG + 50) @(negedge clk);
    i2c_start(); wbyte(8'hA0, ack);
    chk("R9 ack after programming", ack, 1);
    i2c_stop();
    rd_seq(1'b0, 8'h00, 8'h10, 1);
    chk("R5 random read", got[0], 8'h5A);
  endtask

  task automatic t_empty_write();
    bit ack;
    i2c_start(); wbyte(8'hA0, ack); wbyte(8'h10, ack); i2c_stop();
    i2c_start(); wbyte(8'hA0, ack);
    chk("R8 empty write starts no programming", ack, 1);
    i2c_stop();
    rd_seq(1'b0, 8'h00, 8'h10, 1);
    chk("R8 empty write leaves memory", got[0], 8'h5A);
  endtask

  task automatic t_page_roll();
    wr_seq(1'b0, 8'h00, 8'h20, 17, 8'h01, 1'b1);
    rd_seq(1'b0, 8'h00, 8'h20, 16);
    chk("R7 17th byte replaces slot 0", got[0], 8'h11);
    for (int i = 1; i < 16; i++) chk("R7 page byte", got[i], i + 1);
  endtask

  task automatic t_wrap();
    wr_seq(1'b0, 8'h00, 8'hF0, 16, 8'hC0, 1'b1);
    wr_seq(1'b0, 8'h00, 8'h00, 1, 8'h77, 1'b1);
    rd_seq(1'b0, 8'h00, 8'hFE, 3);
    chk("R6 seq read FE", got[0], 8'hCE);
    chk("R6 seq read FF", got[1], 8'hCF);
    chk("R6 wrap to 00", got[2], 8'h77);
  endtask

  task automatic t_segment();
    wr_seq(1'b1, 8'hFE, 8'h10, 1, 8'h99, 1'b1);
    rd_seq(1'b0, 8'h00, 8'h10, 1);
    chk("R3 pointer back to 0 after STOP", got[0], 8'h5A);
    rd_seq(1'b1, 8'h02, 8'h10, 1);
    chk("R2 segment 2 data", got[0], 8'h99);
    rd_seq(1'b0, 8'h00, 8'h10, 1);
    chk("R3 plain access after segment read", got[0], 8'h5A);
  endtask

  task automatic t_bad_addr();
    bit ack;
    i2c_start(); wbyte(8'h61, ack); chk("R4 61h nack", ack, 0);
    q(); chk("R4 released", sda_oe_o, 0);
    i2c_stop();
    i2c_start(); wbyte(8'hA4, ack); chk("R1 A4h nack", ack, 0);
    i2c_stop();
  endtask

  initial begin
    n_chk = 0; n_bad = 0; finished = 1'b0;
    scl_m = 1'b1; sda_m = 1'b1; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_byte_busy();
    t_empty_write();
    t_page_roll();
    t_wrap();
    t_segment();
    t_bad_addr();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule